// File: doc/BRIEF.md
# Load/Store Data Alignment Selector

This block sits between a 32-bit core and a 32-bit memory data bus. It adjusts the data for loads and stores that are narrower than a word. On the read path it takes the word returned by memory, the two low address bits, the access size and a signed flag. It returns the addressed byte or halfword moved down to bit 0. The bits above are filled with zeros, or with copies of the sign bit when a signed load is requested.

On the write path it takes the register value being stored and the access size. It drives a bus word that carries the narrow datum in every lane: a halfword appears in both halves and a byte in all four bytes. The memory can therefore pick up the datum from whichever lane its own enables select. Both paths are purely combinational. The load path and the store path are independent of each other.

Top module: `mem_align_sel`

## Requirements
- R1: With size code 00 (byte), the read result bits [7:0] are the memory lane selected by address bits [1:0] in little-endian order: 0 selects bits [7:0], 1 selects [15:8], 2 selects [23:16], 3 selects [31:24].
- R2: A byte read with the signed flag at 0 returns zeros in result bits [31:8].
- R3: A byte read with the signed flag at 1 fills result bits [31:8] with bit 7 of the selected byte.
- R4: With size code 01 (halfword), address bit 1 selects the halfword: 0 selects bus bits [15:0] and 1 selects [31:16]. The selected halfword appears in result bits [15:0], and address bit 0 has no effect.
- R5: For a halfword read, result bits [31:16] are zero when the signed flag is 0, and copies of bit 15 of the selected halfword when it is 1.
- R6: With size code 10 (word), the read result equals the memory word, whatever the address bits and the signed flag are.
- R7: Size code 11 behaves as a word access on both paths.
- R8: With size code 01, both halves of the write bus carry bits [15:0] of the store value.
- R9: With size code 00, all four bytes of the write bus carry bits [7:0] of the store value.
- R10: With a word size, the write bus equals the store value.
- R11: The write bus depends only on the store value and the size code. The address bits, the signed flag and the memory read word have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_bus_i | input | 32 | Word returned by memory |
| addr_lo_i | input | 2 | Low address bits of the access |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 word |
| signed_i | input | 1 | 1 requests sign extension of a narrow load |
| st_val_i | input | 32 | Register value being stored |
| rd_data_o | output | 32 | Aligned and extended load result |
| wr_bus_o | output | 32 | Lane-replicated store word |

## Verification
Immediate assertions evaluated whenever the inputs settle check several relations between the ports. They check that a byte load lands on the lane named by the address, and that the fill above a narrow load is uniformly zero or uniformly the sign bit. They also check that a word load passes the bus through and that every lane of a narrow store carries the same datum. Some properties are relative, such as the sign fill matching the correct source bit, or address bit 0 and the read word having no effect on the other results. These only show up in the bench's scenarios, which sweep every lane, size and signed setting against an independently written model. Those scenarios use data patterns with the sign bit both set and clear.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRSV = 2'b11
  } acc_size_e;

  // Narrow accesses are the only ones that need lane handling.
  function automatic logic is_byte(input acc_size_e sz);
    return sz == SZ_BYTE;
  endfunction

  function automatic logic is_half(input acc_size_e sz);
    return sz == SZ_HALF;
  endfunction

endpackage

// File: rtl/rd_lane_pick.sv
module rd_lane_pick #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALVES = LANES / 2,
  localparam int ADDR_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]   bus_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [BYTE_W-1:0]   byte_o,
  output logic [2*BYTE_W-1:0] half_o
);

  logic [BYTE_W-1:0]   lane_q [LANES];
  logic [2*BYTE_W-1:0] half_q [HALVES];

  // Little-endian lane order: lane k holds bits [k*BYTE_W +: BYTE_W].
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_q[k] = bus_i[k*BYTE_W +: BYTE_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_q[h] = bus_i[h*2*BYTE_W +: 2*BYTE_W];
  end

  assign byte_o = lane_q[addr_i];
  // The top address bit names the halfword; the lowest bit is ignored.
  assign half_o = half_q[addr_i[ADDR_W-1:1]];

endmodule

// File: rtl/rd_extend.sv
module rd_extend
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]   bus_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic [2*BYTE_W-1:0] half_i,
  input  acc_size_e           size_i,
  input  logic                signed_i,
  output logic                byte_fill_o,
  output logic                half_fill_o,
  output logic [DATA_W-1:0]   data_o
);

  // Fill bit used above the narrow datum: sign bit when signed, else 0.
  assign byte_fill_o = signed_i & byte_i[BYTE_W-1];
  assign half_fill_o = signed_i & half_i[2*BYTE_W-1];

  always_comb begin
    if (is_byte(size_i)) begin
      data_o = {{(DATA_W-BYTE_W){byte_fill_o}}, byte_i};
    end else if (is_half(size_i)) begin
      data_o = {{(DATA_W-2*BYTE_W){half_fill_o}}, half_i};
    end else begin
      data_o = bus_i;
    end
  end

endmodule

// File: rtl/wr_replicate.sv
module wr_replicate
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALVES = LANES / 2
) (
  input  logic [DATA_W-1:0] val_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] bus_o
);

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  for (genvar k = 0; k < LANES; k++) begin : g_brep
    assign byte_rep[k*BYTE_W +: BYTE_W] = val_i[BYTE_W-1:0];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_hrep
    assign half_rep[h*2*BYTE_W +: 2*BYTE_W] = val_i[2*BYTE_W-1:0];
  end

  always_comb begin
    if (is_byte(size_i))      bus_o = byte_rep;
    else if (is_half(size_i)) bus_o = half_rep;
    else                      bus_o = val_i;
  end

endmodule

// File: rtl/mem_align_sel.sv
module mem_align_sel
  import align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int ADDR_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rd_bus_i,
  input  logic [ADDR_W-1:0] addr_lo_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] st_val_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] wr_bus_o
);

  acc_size_e           size_e;
  logic [BYTE_W-1:0]   sel_byte;
  logic [2*BYTE_W-1:0] sel_half;
  logic                byte_fill;
  logic                half_fill;

  assign size_e = acc_size_e'(size_i);

  rd_lane_pick #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) pick_i (
    .bus_i  (rd_bus_i),
    .addr_i (addr_lo_i),
    .byte_o (sel_byte),
    .half_o (sel_half)
  );

  rd_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) ext_i (
    .bus_i       (rd_bus_i),
    .byte_i      (sel_byte),
    .half_i      (sel_half),
    .size_i      (size_e),
    .signed_i    (signed_i),
    .byte_fill_o (byte_fill),
    .half_fill_o (half_fill),
    .data_o      (rd_data_o)
  );

  wr_replicate #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) rep_i (
    .val_i  (st_val_i),
    .size_i (size_e),
    .bus_o  (wr_bus_o)
  );

  // Port-level checks across the pick, extend and replicate pieces.
  always_comb begin
    if (size_e == SZ_BYTE) begin
      assert_byte_lane_R1: assert (rd_data_o[BYTE_W-1:0] == rd_bus_i[addr_lo_i*BYTE_W +: BYTE_W]);
      if (!signed_i) begin
        assert_byte_zero_R2: assert (rd_data_o[DATA_W-1:BYTE_W] == '0);
      end else begin
        assert_byte_sign_R3: assert (($countones(rd_data_o[DATA_W-1:BYTE_W]) == 0 && !rd_data_o[BYTE_W-1])
                                  || ($countones(rd_data_o[DATA_W-1:BYTE_W]) == DATA_W-BYTE_W && rd_data_o[BYTE_W-1]));
      end
      assert_byte_rep_R9: assert (wr_bus_o == {LANES{st_val_i[BYTE_W-1:0]}});
    end
    if (size_e == SZ_HALF) begin
      assert_half_fill_R5: assert ((!signed_i && rd_data_o[DATA_W-1:2*BYTE_W] == '0)
                                || (signed_i && $countones(rd_data_o[DATA_W-1:2*BYTE_W - 1]) inside {0, DATA_W-2*BYTE_W+1}));
      assert_half_rep_R8: assert (wr_bus_o[DATA_W-1:DATA_W/2] == wr_bus_o[DATA_W/2-1:0]);
    end
    if (size_e == SZ_WORD || size_e == SZ_WRSV) begin
      assert_word_rd_R6: assert (rd_data_o == rd_bus_i);
      assert_word_wr_R10: assert (wr_bus_o == st_val_i);
    end
  end

endmodule

// File: tb/mem_align_sel_tb.sv
`timescale 1ns/1ps
module mem_align_sel_tb_top;

  typedef struct {
    logic [31:0] exp_rd;
    logic [31:0] exp_wr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_bus;
  logic [1:0]  addr_lo;
  logic [1:0]  size;
  logic        sgn;
  logic [31:0] st_val;
  logic [31:0] rd_data;
  logic [31:0] wr_bus;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  mem_align_sel dut_i (
    .rd_bus_i  (rd_bus),
    .addr_lo_i (addr_lo),
    .size_i    (size),
    .signed_i  (sgn),
    .st_val_i  (st_val),
    .rd_data_o (rd_data),
    .wr_bus_o  (wr_bus)
  );

  // Independent model written from the requirements.
  function automatic logic [31:0] model_rd(logic [31:0] bus, logic [1:0] a, logic [1:0] sz, logic s);
    logic [31:0] r;
    case (sz)
      2'b00: begin
        r = (bus >> (32'(a) * 8)) & 32'hFF;
        if (s && r[7]) r = r | 32'hFFFF_FF00;
      end
      2'b01: begin
        r = a[1] ? {16'h0, bus[31:16]} : {16'h0, bus[15:0]};
        if (s && r[15]) r = r | 32'hFFFF_0000;
      end
      default: r = bus;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] model_wr(logic [31:0] v, logic [1:0] sz);
    case (sz)
      2'b00:   return {v[7:0], v[7:0], v[7:0], v[7:0]};
      2'b01:   return {v[15:0], v[15:0]};
      default: return v;
    endcase
  endfunction

  task automatic drive(logic [31:0] bus, logic [1:0] a, logic [1:0] sz, logic s,
                       logic [31:0] v, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    rd_bus = bus; addr_lo = a; size = sz; sgn = s; st_val = v;
    e.exp_rd = model_rd(bus, a, sz, s);
    e.exp_wr = model_wr(v, sz);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: samples at the falling edge, after the driver settled inputs.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (rd_data !== e.exp_rd || wr_bus !== e.exp_wr) begin
        failures++;
        $display("FAIL %s rd=%08h exp_rd=%08h wr=%08h exp_wr=%08h",
                 e.tag, rd_data, e.exp_rd, wr_bus, e.exp_wr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rd_bus = '0; addr_lo = '0; size = '0; sgn = 1'b0; st_val = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs give zero outputs (R1, R9).
    drive(32'h0, 2'd0, 2'b00, 1'b0, 32'h0, "R1 idle");
    // R1, R2, R3: every lane, both signedness settings, sign bit set and clear.
    for (int a = 0; a < 4; a++) begin
      drive(32'h80F1_7F92, 2'(a), 2'b00, 1'b0, 32'h1234_5678, "R1 R2 byte unsigned");
      drive(32'h80F1_7F92, 2'(a), 2'b00, 1'b1, 32'h1234_5678, "R1 R3 byte signed");
      drive(32'h017E_8003, 2'(a), 2'b00, 1'b1, 32'hCAFE_BEEF, "R3 byte signed alt");
    end
    // R4, R5: both halves, address bit 0 toggled, both signs.
    for (int a = 0; a < 4; a++) begin
      drive(32'h8001_7FFE, 2'(a), 2'b01, 1'b0, 32'hA5A5_3C3C, "R4 R5 half unsigned");
      drive(32'h8001_7FFE, 2'(a), 2'b01, 1'b1, 32'hA5A5_3C3C, "R4 R5 half signed");
      drive(32'h7FFF_FFFF, 2'(a), 2'b01, 1'b1, 32'h0000_81FF, "R5 half signed alt");
    end
    // R6, R10, R11: word ignores address and sign.
    for (int a = 0; a < 4; a++) begin
      drive(32'hDEAD_BEEF, 2'(a), 2'b10, 1'(a & 1), 32'h8765_4321, "R6 R10 R11 word");
    end
    // R7: reserved code acts as word.
    drive(32'hF00D_8080, 2'd1, 2'b11, 1'b1, 32'h1357_9BDF, "R7 code 11");
    drive(32'h0000_0080, 2'd3, 2'b11, 1'b0, 32'hFFFF_0001, "R7 code 11 alt");
    // R8, R9, R11: store replication unaffected by read-side inputs.
    drive(32'hFFFF_FFFF, 2'd3, 2'b01, 1'b1, 32'h1111_BEEF, "R8 R11 half store");
    drive(32'h0000_0000, 2'd0, 2'b01, 1'b0, 32'h1111_BEEF, "R8 R11 half store alt");
    drive(32'h1234_5678, 2'd2, 2'b00, 1'b1, 32'h9999_99C3, "R9 R11 byte store");
    drive(32'h8765_4321, 2'd1, 2'b00, 1'b0, 32'h9999_99C3, "R9 R11 byte store alt");
    wait (sb_q.size() == 0);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule